// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit recovers bit timing from a CAN-style serial receive line. A prescaler outside the block supplies a one-cycle tick for every time quantum. The unit divides each bit into three parts: a one-quantum sync segment, a first timing segment and a second timing segment. It takes the bit value at the end of the first segment and pulses a strobe there. It pulses a second strobe on every sync quantum, which marks the start of a bit.

Two 8-bit timing registers configure the unit. They set both segment lengths, one or three samples per bit, the resynchronization jump width, which edges are used to resynchronize, and whether the raw input is inverted first. Software can change the registers only while the init-mode input is high. While the bus is idle, the first recessive-to-dominant edge causes a hard sync. After that, edges pull the bit timing towards the transmitter by at most the jump width, and at most once per bit.

Top module: `canBitTiming`

## Requirements
- R1: After reset both timing registers read 0x00, `rxBit` is 1 (recessive), and neither strobe is high while no tick is given.
- R2: The registers are written only when `cfgWe` and `initMode` are both high at a clock edge. Other writes are ignored. `cfgSel`=0 selects the timing register: TS1 in bits 3:0, TS2 in bits 6:4, triple-sample enable in bit 7. `cfgSel`=1 selects the sync register: jump code SJW in bits 1:0, both-edge enable in bit 2, input inversion in bit 3.
- R3: Bits 7:4 of the sync register are always stored as 0 and always read back as 0.
- R4: With no resynchronization, `bitStart` is high on the sync quantum. `samplePoint` is high TS1+1 ticks later. The next `bitStart` comes TS1+TS2+3 ticks after the first one.
- R5: The bus counts as idle after reset, and again after 11 sampled recessive bits in a row. While the bus is idle, a recessive-to-dominant edge at any tick causes a hard sync: `bitStart` on that same tick.
- R6: An edge e quanta after the sync quantum, in the first segment, moves the sample point later by min(e, SJW+1) quanta.
- R7: An edge in the second segment with r quanta of that segment still left (the edge quantum included) works as follows. If r ≤ SJW+1, that quantum becomes the sync quantum of the next bit. Otherwise the second segment is cut by SJW+1 quanta.
- R8: Only one resynchronization happens per bit, and a hard sync uses up the one for its bit. Later edges in the same bit have no effect.
- R9: With the both-edge enable clear, only recessive-to-dominant edges resynchronize. With it set, rising edges also do.
- R10: With the inversion bit set, the raw input is inverted before edge detection and sampling. Dominant is logic 0 after this stage.
- R11: With triple sampling set, the bit value is the majority of the line over the last three quanta, ending at the sample point. With it clear, the bit value is the line at the sample point.
- R12: `rxBit` takes the sampled value on the clock edge of the sample-point tick and holds it until the next sample point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initMode | input | 1 | Enables writes to the timing registers |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 1 | Register select: 0 timing, 1 sync |
| cfgWdata | input | 8 | Register write data |
| cfgRdata | output | 8 | Value of the selected register |
| tqTick | input | 1 | One-cycle pulse per time quantum |
| rxRaw | input | 1 | Raw receive line |
| rxBit | output | 1 | Last sampled bit value |
| samplePoint | output | 1 | High on the tick that samples the bit |
| bitStart | output | 1 | High on the sync-quantum tick |

## Verification
The assertions take two things for granted. The timing registers are rewritten only between runs of the line, never while a bit is being timed. `rxRaw` changes only between ticks, so each quantum sees one stable level. The stimulus applies each configuration straight after reset, while no tick is running, and drives the line one quantum at a time through a task that changes `rxRaw` just before raising the tick. Edges are placed at chosen quantum positions so that each early, late and clamped case falls at a known tick index.

// File: rtl/canBtPkg.sv
package canBtPkg;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;
  localparam int SJW_W = 2;

  typedef enum logic [1:0] {PH_SYNC, PH_SEG1, PH_SEG2} phaseT;

  typedef struct packed {
    logic [TS1_W-1:0] ts1;
    logic [TS2_W-1:0] ts2;
    logic [SJW_W-1:0] sjw;
    logic             triple;
    logic             bothEdges;
    logic             invert;
  } cfgT;

  // control -> datapath strobes
  typedef struct packed {
    logic takeBit;
    logic bitStart;
  } ctrlStrobeT;

  // datapath -> control line information
  typedef struct packed {
    logic edgeFall;
    logic edgeSoft;
    logic sampleVal;
  } lineInfoT;
endpackage

// File: rtl/canBtData.sv
module canBtData
  import canBtPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       initMode,
  input  logic       cfgWe,
  input  logic       cfgSel,
  input  logic [7:0] cfgWdata,
  output logic [7:0] cfgRdata,
  input  logic       tqTick,
  input  logic       rxRaw,
  input  ctrlStrobeT ctl,
  output lineInfoT   line,
  output cfgT        cfg,
  output logic       rxBit
);
  logic [7:0] regTime;
  logic [7:0] regSync;
  logic [1:0] hist;      // hist[0] = line at previous tick, hist[1] = one before
  logic       rxPol;
  logic       riseNow;
  logic       fallNow;
  logic       majority;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regTime <= '0;
      regSync <= '0;
    end else if (cfgWe && initMode) begin
      if (cfgSel) regSync <= {4'b0000, cfgWdata[3:0]};
      else        regTime <= cfgWdata;
    end
  end

  assign cfgRdata = cfgSel ? regSync : regTime;

  assign cfg.ts1       = regTime[3:0];
  assign cfg.ts2       = regTime[6:4];
  assign cfg.triple    = regTime[7];
  assign cfg.sjw       = regSync[1:0];
  assign cfg.bothEdges = regSync[2];
  assign cfg.invert    = regSync[3];

  assign rxPol = rxRaw ^ cfg.invert;

  always_ff @(posedge clk) begin
    if (!rstN)       hist <= 2'b11;
    else if (tqTick) hist <= {hist[0], rxPol};
  end

  assign fallNow  = tqTick &  hist[0] & ~rxPol;
  assign riseNow  = tqTick & ~hist[0] &  rxPol;
  assign majority = (hist[1] & hist[0]) | (hist[1] & rxPol) | (hist[0] & rxPol);

  assign line.edgeFall  = fallNow;
  assign line.edgeSoft  = fallNow | (cfg.bothEdges & riseNow);
  assign line.sampleVal = cfg.triple ? majority : rxPol;

  always_ff @(posedge clk) begin
    if (!rstN)            rxBit <= 1'b1;
    else if (ctl.takeBit) rxBit <= line.sampleVal;
  end

  p_cfg_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    !initMode |=> ($stable(regTime) && $stable(regSync)));

  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    regSync[7:4] == 4'b0000);

  p_bit_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.takeBit |=> $stable(rxBit));

  p_majority_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.takeBit && cfg.triple && hist == 2'b00 && !rxPol) |=> !rxBit);
endmodule

// File: rtl/canBtCtrl.sv
module canBtCtrl
  import canBtPkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tqTick,
  input  cfgT        cfg,
  input  lineInfoT   line,
  output ctrlStrobeT ctl
);
  localparam int CNT_W  = TS1_W + 1;
  localparam int JMP_W  = SJW_W + 1;
  localparam int IDLE_W = $clog2(IDLE_BITS + 1);

  phaseT             phase, phaseN;
  logic [CNT_W-1:0]  cnt, cntN;
  logic [JMP_W-1:0]  ext, extN, extEff;
  logic [JMP_W-1:0]  shrink, shrN, shrEff;
  logic              used, usedN;
  logic [IDLE_W-1:0] idleCnt, idleCntN;
  logic              idle;
  logic [JMP_W-1:0]  jump;
  logic [CNT_W-1:0]  cntInc, remain;
  logic              softOk, hardSync, strobeStart, strobeSample;

  assign idle     = (idleCnt == IDLE_W'(IDLE_BITS));
  assign jump     = {1'b0, cfg.sjw} + JMP_W'(1);
  assign cntInc   = cnt + CNT_W'(1);
  assign remain   = CNT_W'(cfg.ts2) + CNT_W'(1) - cnt;
  assign softOk   = line.edgeSoft && !used;
  assign hardSync = tqTick && line.edgeFall && idle;

  always_comb begin
    phaseN = phase;  cntN = cnt;  extN = ext;  shrN = shrink;
    usedN = used;    idleCntN = idleCnt;
    extEff = ext;    shrEff = shrink;
    strobeStart = 1'b0;  strobeSample = 1'b0;
    if (tqTick) begin
      if (hardSync) begin
        strobeStart = 1'b1;
        phaseN = PH_SEG1; cntN = '0; extN = '0; shrN = '0; usedN = 1'b1;
        idleCntN = '0;
      end else begin
        unique case (phase)
          PH_SYNC: begin
            strobeStart = 1'b1;
            phaseN = PH_SEG1; cntN = '0; extN = '0; shrN = '0;
            usedN = line.edgeSoft;
          end
          PH_SEG1: begin
            if (softOk) begin
              usedN  = 1'b1;
              extEff = (cntInc > CNT_W'(jump)) ? jump : cntInc[JMP_W-1:0];
            end
            extN = extEff;
            if (cnt == CNT_W'(cfg.ts1) + CNT_W'(extEff)) begin
              strobeSample = 1'b1;
              phaseN = PH_SEG2; cntN = '0;
            end else begin
              cntN = cntInc;
            end
          end
          PH_SEG2: begin
            if (softOk && remain <= CNT_W'(jump)) begin
              strobeStart = 1'b1;
              phaseN = PH_SEG1; cntN = '0; extN = '0; shrN = '0; usedN = 1'b1;
            end else begin
              if (softOk) begin
                usedN  = 1'b1;
                shrEff = jump;
              end
              shrN = shrEff;
              if (cnt == CNT_W'(cfg.ts2) - CNT_W'(shrEff)) begin
                phaseN = PH_SYNC; cntN = '0;
              end else begin
                cntN = cntInc;
              end
            end
          end
          default: phaseN = PH_SYNC;
        endcase
        if (strobeSample) begin
          if (!line.sampleVal)  idleCntN = '0;
          else if (!idle)       idleCntN = idleCnt + IDLE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_SYNC; cnt <= '0; ext <= '0; shrink <= '0;
      used <= 1'b0; idleCnt <= IDLE_W'(IDLE_BITS);
    end else begin
      phase <= phaseN; cnt <= cntN; ext <= extN; shrink <= shrN;
      used <= usedN; idleCnt <= idleCntN;
    end
  end

  assign ctl.takeBit  = strobeSample;
  assign ctl.bitStart = strobeStart;

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.bitStart && ctl.takeBit));

  p_start_to_seg1_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.bitStart |=> (phase == PH_SEG1 && cnt == '0));

  p_sample_to_seg2_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takeBit |=> (phase == PH_SEG2 && cnt == '0));

  p_one_resync_r8: assert property (@(posedge clk) disable iff (!rstN)
    (used && phase != PH_SYNC && !hardSync) |=> used);
endmodule

// File: rtl/canBitTiming.sv
module canBitTiming
  import canBtPkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       initMode,
  input  logic       cfgWe,
  input  logic       cfgSel,
  input  logic [7:0] cfgWdata,
  output logic [7:0] cfgRdata,
  input  logic       tqTick,
  input  logic       rxRaw,
  output logic       rxBit,
  output logic       samplePoint,
  output logic       bitStart
);
  ctrlStrobeT ctl;
  lineInfoT   line;
  cfgT        cfg;

  canBtData u_data (
    .clk(clk), .rstN(rstN), .initMode(initMode), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .tqTick(tqTick), .rxRaw(rxRaw), .ctl(ctl), .line(line),
    .cfg(cfg), .rxBit(rxBit)
  );

  canBtCtrl #(.IDLE_BITS(IDLE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tqTick(tqTick), .cfg(cfg),
    .line(line), .ctl(ctl)
  );

  assign samplePoint = ctl.takeBit;
  assign bitStart    = ctl.bitStart;
endmodule

// File: tb/test_canBitTiming.sv
`timescale 1ns/100ps
module test_canBitTiming;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       initMode = 1'b0;
  logic       cfgWe = 1'b0;
  logic       cfgSel = 1'b0;
  logic [7:0] cfgWdata = '0;
  logic [7:0] cfgRdata;
  logic       tqTick = 1'b0;
  logic       rxRaw = 1'b1;
  logic       rxBit, samplePoint, bitStart;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;
  logic seenBs, seenSp, seenBit;
  logic [63:0] bsMask, spMask, bitAfter;

  always #2.5 clk = ~clk;

  canBitTiming i_canBitTiming (
    .clk(clk), .rstN(rstN), .initMode(initMode), .cfgWe(cfgWe),
    .cfgSel(cfgSel), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .tqTick(tqTick), .rxRaw(rxRaw), .rxBit(rxBit),
    .samplePoint(samplePoint), .bitStart(bitStart)
  );

  // ts1, ts2, ticks before edge, expected sample offset, expected next start
  localparam logic [39:0] VEC [5] = '{
    {8'd0,  8'd0, 8'd3, 8'd1,  8'd3},
    {8'd3,  8'd2, 8'd5, 8'd4,  8'd8},
    {8'd15, 8'd7, 8'd0, 8'd16, 8'd25},
    {8'd7,  8'd1, 8'd9, 8'd8,  8'd11},
    {8'd1,  8'd4, 8'd2, 8'd2,  8'd8}
  };

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; initMode = 1'b0; cfgWe = 1'b0; tqTick = 1'b0; rxRaw = 1'b1;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrCfg(input logic sel, input logic [7:0] d, input logic im);
    @(negedge clk);
    initMode = im; cfgSel = sel; cfgWdata = d; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0; initMode = 1'b0;
  endtask

  task automatic tick(input logic v);
    @(negedge clk);
    rxRaw = v; tqTick = 1'b1;
    #1;
    seenBs = bitStart; seenSp = samplePoint;
    @(negedge clk);
    tqTick = 1'b0;
    seenBit = rxBit;
  endtask

  task automatic runPat(input logic [63:0] pat, input int n);
    bsMask = '0; spMask = '0; bitAfter = '0;
    for (int i = 0; i < n; i++) begin
      tick(pat[i]);
      bsMask[i] = seenBs; spMask[i] = seenSp; bitAfter[i] = seenBit;
    end
  endtask

  task automatic setup(input logic [7:0] t, input logic [7:0] s);
    doReset();
    wrCfg(1'b0, t, 1'b1);
    wrCfg(1'b1, s, 1'b1);
  endtask

  initial begin
    #750000;
    if (!finished) begin
      nFail++; nChk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int spAt, bsAt;
    doReset();
    // R1 reset state
    #1;
    cfgSel = 1'b0; #1; check("R1 timing reg", cfgRdata, 0);
    cfgSel = 1'b1; #1; check("R1 sync reg", cfgRdata, 0);
    check("R1 rxBit", rxBit, 1);
    check("R1 strobes", {samplePoint, bitStart}, 0);

    // R2 lock outside init mode
    wrCfg(1'b0, 8'h5A, 1'b0);
    cfgSel = 1'b0; #1; check("R2 locked write", cfgRdata, 0);
    wrCfg(1'b0, 8'h5A, 1'b1);
    cfgSel = 1'b0; #1; check("R2 init write", cfgRdata, 8'h5A);
    // R3 unused bits
    wrCfg(1'b1, 8'hFF, 1'b1);
    cfgSel = 1'b1; #1; check("R3 unused bits", cfgRdata, 8'h0F);

    // R4 / R5 table: hard sync from idle after free-running ticks
    foreach (VEC[k]) begin
      setup({1'b0, VEC[k][34:32], VEC[k][35:32+0] & 4'h0 | VEC[k][35:32]}, 8'h00);
      setup({1'b0, VEC[k][30:28] & 3'h0 | VEC[k][26:24], VEC[k][35:32]}, 8'h00);
      for (int p = 0; p < int'(VEC[k][23:16]); p++) tick(1'b1);
      runPat(64'h0, int'(VEC[k][7:0]) + 1);
      check("R5 hard sync start", bsMask[0], 1);
      spAt = -1; bsAt = -1;
      for (int i = 63; i >= 1; i--) begin
        if (spMask[i]) spAt = i;
        if (bsMask[i]) bsAt = i;
      end
      check("R4 sample offset", spAt, int'(VEC[k][15:8]));
      check("R4 next bit start", bsAt, int'(VEC[k][7:0]));
    end

    // R10 inversion: raw 0 is recessive, raw 1 dominant
    setup(8'h23, 8'h08);
    tick(1'b0); tick(1'b0);
    runPat(64'hFFFF_FFFF_FFFF_FFFF, 6);
    check("R10 sync on inverted edge", bsMask[0], 1);
    check("R10 sample at 4", spMask[4], 1);
    check("R10 bit dominant", bitAfter[4], 0);

    // R11 / R12 triple majority
    setup(8'hA3, 8'h00);
    runPat(64'h4, 6);
    check("R12 hold before sample", bitAfter[3], 1);
    check("R11 majority 100", bitAfter[4], 0);
    setup(8'hA3, 8'h00);
    runPat(64'hC, 6);
    check("R11 majority 110", bitAfter[4], 1);
    check("R12 hold after sample", bitAfter[5], 1);
    setup(8'h23, 8'h00);
    runPat(64'hC, 6);
    check("R11 single sample", bitAfter[4], 0);

    // R6 late edge clamped, R9 rising ignored
    setup(8'h35, 8'h01);
    runPat(64'h3000, 26);
    check("R9 rising ignored", spMask[18], 0);
    check("R6 late clamp", spMask[19], 1);
    check("R5 no hard sync when busy", bsMask[14], 0);
    check("R6 next start", bsMask[24], 1);
    // R6 unclamped
    setup(8'h35, 8'h03);
    runPat(64'h3000, 26);
    check("R6 late unclamped", spMask[20], 1);
    // R9 both edges
    setup(8'h35, 8'h05);
    runPat(64'h3000, 26);
    check("R9 rising resync", spMask[18], 1);
    // R8 one resync per bit
    setup(8'h35, 8'h07);
    runPat(64'h7FFF_D000, 26);
    check("R8 second edge ignored", spMask[18], 1);
    check("R8 no extra shift", spMask[20], 0);

    // R7 early edge
    setup(8'h35, 8'h01);
    runPat(64'hFFFFE, 30);
    check("R7 early becomes sync", bsMask[20], 1);
    check("R7 sample after early", spMask[26], 1);
    setup(8'h35, 8'h00);
    runPat(64'hFFFFE, 30);
    check("R7 shortened not sync", bsMask[20], 0);
    check("R7 shortened start", bsMask[21], 1);
    check("R7 sample after shorten", spMask[27], 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule